// File: doc/BRIEF.md
# I2C Bus Master with Event-Hold Clocking

This block is a single-master I2C controller that software drives through a small register window. Software places a byte in a data register, requests bus actions by setting bits in a control register, and reads a status register that reports a code for the most recent bus event. The control register has two write addresses. A 1 written through the set address turns bits on. A 1 written through the clear address turns bits off. Zero bits are left alone, so no read-modify-write is ever needed.

The controller stops after each bus event: a start, a repeated start, a byte sent together with the acknowledge it collected, or a byte received together with the acknowledge it returned. It then raises an event flag and keeps SCL pulled low for as long as that flag stays set. Any start, stop or byte that software queues in the meantime waits, and it begins only after software clears the flag. A delay in the software therefore cannot lose or reorder a bus action. SCL and SDA are open-drain outputs. A quarter-period count chosen at a pin sets the SCL timing.

Top module: `i2c_hold_master`

## Requirements
- R1: After reset the control value reads 0x00, the status reads 0xF8, the event flag output is 0, and both lines are released.
- R2: Control bits are start request at bit 5, stop request at bit 4, event flag at bit 3 and acknowledge enable at bit 2. A write to address 0 sets each bit written as 1. A write to address 3 clears each bit written as 1. Reading address 0 returns the control value. Software cannot set the event flag, because the set address ignores bit 3.
- R3: With the bus idle and the flag clear, a start request produces a start condition, sets the flag, and loads status 0x08.
- R4: While the flag is set, SCL is held low, SDA does not change, and the status does not change, however long software waits.
- R5: If the start request is set when software clears the flag during a transfer, a repeated start is produced and status 0x10 is loaded.
- R6: A byte sent from the data register (address 2) goes out MSB first. The first byte after a start is the address, and its bit 0 selects read when it is 1. Status is 0x18 or 0x20 for an acknowledged or refused write address, 0x40 or 0x48 for an acknowledged or refused read address, and 0x28 or 0x30 for an acknowledged or refused data byte.
- R7: After a read address, each flag clear receives one byte. The byte is answered with ACK if acknowledge enable is set at that clear, and with NACK otherwise. Status is 0x50 after an ACK and 0x58 after a NACK. The received byte is in the data register when the flag rises.
- R8: A stop request, acted on when the flag is cleared, puts a stop condition on the bus. The stop bit then clears itself, the status returns to 0xF8, the flag stays clear, and both lines are released.
- R9: The start request is never cleared by hardware. It wins over both a pending stop and the next byte, and a stop still pending after the repeated start is carried out at the next flag clear.
- R10: Each quarter of an SCL bit lasts `scl_quarter`+1 clocks, so SCL stays high for 2·(`scl_quarter`+1) clocks in every data or acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_quarter | input | DIV_W | Clocks per SCL quarter-bit, minus one |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 control set / read, 1 status, 2 data, 3 control clear |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Event flag |

## Verification
The bench builds the block with the default DIV_W of 8. It changes `scl_quarter` between transactions, using values of 1, 2 and 3, so the same byte sequencing runs under several SCL rates, and it measures the high time of SCL against R10. A short quarter keeps each byte near 150 clocks. That leaves room in the cycle budget for long stalls with the flag set, during which start and stop requests are queued behind it. It also leaves room for randomized write-then-read transactions, all against a modeled memory slave whose data-acknowledge behavior can be switched.

// File: rtl/i2c_hold_pkg.sv
package i2c_hold_pkg;
  typedef enum logic [2:0] {
    EN_IDLE, EN_HOLD, EN_START, EN_RSTART, EN_BYTE, EN_STOP
  } eng_state_t;

  localparam int CB_AA  = 2;
  localparam int CB_SI  = 3;
  localparam int CB_STO = 4;
  localparam int CB_STA = 5;

  localparam logic [1:0] RA_SET  = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_DATA = 2'd2;
  localparam logic [1:0] RA_CLR  = 2'd3;

  localparam logic [7:0] SC_START  = 8'h08;
  localparam logic [7:0] SC_RSTART = 8'h10;
  localparam logic [7:0] SC_AW_ACK = 8'h18;
  localparam logic [7:0] SC_AW_NAK = 8'h20;
  localparam logic [7:0] SC_TX_ACK = 8'h28;
  localparam logic [7:0] SC_TX_NAK = 8'h30;
  localparam logic [7:0] SC_AR_ACK = 8'h40;
  localparam logic [7:0] SC_AR_NAK = 8'h48;
  localparam logic [7:0] SC_RX_ACK = 8'h50;
  localparam logic [7:0] SC_RX_NAK = 8'h58;
  localparam logic [7:0] SC_IDLE   = 8'hF8;
endpackage

// File: rtl/i2c_hold_tick.sv
module i2c_hold_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] quarter,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q >= quarter);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_hold_regs.sv
module i2c_hold_regs
  import i2c_hold_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          ev_valid,
  input  logic [7:0]    ev_code,
  input  logic          rx_load,
  input  logic [DW-1:0] rx_data,
  input  logic          sto_done,
  output logic          sta,
  output logic          sto,
  output logic          si,
  output logic          aa,
  output logic [DW-1:0] dat
);
  logic [7:0] stat_q;
  logic       set_w, clr_w;

  assign set_w = we && (addr == RA_SET);
  assign clr_w = we && (addr == RA_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta <= 1'b0; sto <= 1'b0; si <= 1'b0; aa <= 1'b0;
      dat <= '0;   stat_q <= SC_IDLE;
    end else begin
      if (set_w && wdata[CB_STA])      sta <= 1'b1;
      else if (clr_w && wdata[CB_STA]) sta <= 1'b0;
      if (sto_done)                    sto <= 1'b0;
      else if (set_w && wdata[CB_STO]) sto <= 1'b1;
      else if (clr_w && wdata[CB_STO]) sto <= 1'b0;
      if (ev_valid)                    si <= 1'b1;
      else if (clr_w && wdata[CB_SI])  si <= 1'b0;
      if (set_w && wdata[CB_AA])       aa <= 1'b1;
      else if (clr_w && wdata[CB_AA])  aa <= 1'b0;
      if (rx_load)                          dat <= rx_data;
      else if (we && (addr == RA_DATA))     dat <= wdata;
      if (ev_valid)      stat_q <= ev_code;
      else if (sto_done) stat_q <= SC_IDLE;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_SET: begin
        rdata[CB_STA] = sta;
        rdata[CB_STO] = sto;
        rdata[CB_SI]  = si;
        rdata[CB_AA]  = aa;
      end
      RA_STAT: rdata = stat_q;
      RA_DATA: rdata = dat;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_hold_engine.sv
module i2c_hold_engine
  import i2c_hold_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sta,
  input  logic       sto,
  input  logic       si,
  input  logic       aa,
  input  logic [7:0] dat,
  input  logic       sda_in,
  output logic       scl_lo,
  output logic       sda_lo,
  output logic       ev_valid,
  output logic [7:0] ev_code,
  output logic       rx_load,
  output logic [7:0] rx_data,
  output logic       sto_done
);
  eng_state_t state_q;
  logic [1:0] ph_q;
  logic [3:0] bitn_q;
  logic [7:0] shift_q;
  logic       ack_q, aa_q, rw_q, addr_q, rxm_q;
  logic       rx_data_bits, ack_bit;

  assign rx_data_bits = rxm_q && !addr_q;
  assign ack_bit      = (bitn_q == 4'd8);
  assign rx_data      = shift_q;

  always_comb begin
    ev_valid = 1'b0;
    ev_code  = SC_IDLE;
    case (state_q)
      EN_START: begin
        ev_valid = tick && (ph_q == 2'd1);
        ev_code  = SC_START;
      end
      EN_RSTART: begin
        ev_valid = tick && (ph_q == 2'd3);
        ev_code  = SC_RSTART;
      end
      EN_BYTE: begin
        ev_valid = tick && (ph_q == 2'd3) && ack_bit;
        if (addr_q)            ev_code = rw_q ? (ack_q ? SC_AR_ACK : SC_AR_NAK)
                                              : (ack_q ? SC_AW_ACK : SC_AW_NAK);
        else if (rxm_q)        ev_code = aa_q ? SC_RX_ACK : SC_RX_NAK;
        else                   ev_code = ack_q ? SC_TX_ACK : SC_TX_NAK;
      end
      default: ;
    endcase
  end

  assign rx_load  = ev_valid && (state_q == EN_BYTE) && rx_data_bits;
  assign sto_done = ((state_q == EN_STOP) && tick && (ph_q == 2'd2)) ||
                    ((state_q == EN_IDLE) && sto && !sta);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EN_IDLE; ph_q <= '0; bitn_q <= '0; shift_q <= '0;
      ack_q <= 1'b0; aa_q <= 1'b0; rw_q <= 1'b0; addr_q <= 1'b0; rxm_q <= 1'b0;
      scl_lo <= 1'b0; sda_lo <= 1'b0;
    end else begin
      case (state_q)
        EN_IDLE: if (sta) begin state_q <= EN_START; ph_q <= '0; end
        EN_HOLD: if (!si) begin
          ph_q <= '0;
          if (sta)      state_q <= EN_RSTART;
          else if (sto) state_q <= EN_STOP;
          else begin
            state_q <= EN_BYTE;
            bitn_q  <= '0;
            shift_q <= dat;
            aa_q    <= aa;
            if (addr_q) rw_q <= dat[0];
          end
        end
        EN_START: if (tick) begin
          ph_q <= ph_q + 2'd1;
          if (ph_q == 2'd0) sda_lo <= 1'b1;
          else begin scl_lo <= 1'b1; state_q <= EN_HOLD; addr_q <= 1'b1; end
        end
        EN_RSTART: if (tick) begin
          ph_q <= ph_q + 2'd1;
          case (ph_q)
            2'd0:    sda_lo <= 1'b0;
            2'd1:    scl_lo <= 1'b0;
            2'd2:    sda_lo <= 1'b1;
            default: begin scl_lo <= 1'b1; state_q <= EN_HOLD; addr_q <= 1'b1; end
          endcase
        end
        EN_STOP: if (tick) begin
          ph_q <= ph_q + 2'd1;
          case (ph_q)
            2'd0:    sda_lo <= 1'b1;
            2'd1:    scl_lo <= 1'b0;
            default: begin
              sda_lo <= 1'b0; state_q <= EN_IDLE; rxm_q <= 1'b0; addr_q <= 1'b0;
            end
          endcase
        end
        EN_BYTE: if (tick) begin
          ph_q <= ph_q + 2'd1;
          case (ph_q)
            2'd0: sda_lo <= ack_bit ? (rx_data_bits && aa_q)
                                    : (!rx_data_bits && !shift_q[7]);
            2'd1: scl_lo <= 1'b0;
            2'd2: if (ack_bit) ack_q <= !sda_in;
                  else         shift_q <= {shift_q[6:0], sda_in};
            default: begin
              scl_lo <= 1'b1;
              if (ack_bit) begin
                state_q <= EN_HOLD;
                if (addr_q) begin rxm_q <= rw_q; addr_q <= 1'b0; end
              end else bitn_q <= bitn_q + 4'd1;
            end
          endcase
        end
        default: state_q <= EN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_hold_master.sv
module i2c_hold_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] scl_quarter,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             irq
);
  logic       tick, sta, sto, si, aa, ev_valid, rx_load, sto_done;
  logic [7:0] dat, ev_code, rx_data;

  i2c_hold_tick #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .quarter(scl_quarter), .tick(tick)
  );

  i2c_hold_regs #(.DW(8)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ev_valid(ev_valid), .ev_code(ev_code), .rx_load(rx_load),
    .rx_data(rx_data), .sto_done(sto_done), .sta(sta), .sto(sto), .si(si),
    .aa(aa), .dat(dat)
  );

  i2c_hold_engine engine_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sta(sta), .sto(sto), .si(si),
    .aa(aa), .dat(dat), .sda_in(sda_in), .scl_lo(scl_oe), .sda_lo(sda_oe),
    .ev_valid(ev_valid), .ev_code(ev_code), .rx_load(rx_load),
    .rx_data(rx_data), .sto_done(sto_done)
  );

  assign irq = si;
endmodule

// File: rtl/i2c_hold_checker.sv
module i2c_hold_checker (
  input logic clk,
  input logic rst_n,
  input logic si,
  input logic sto,
  input logic sto_done,
  input logic ev_valid,
  input logic scl_oe,
  input logic sda_oe
);
  a_r2_si_from_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si) |-> $past(ev_valid));

  a_r4_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    si |-> scl_oe);

  a_r4_sda_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (si && $past(si)) |-> $stable(sda_oe));

  a_r8_stop_done: assert property (@(posedge clk) disable iff (!rst_n)
    sto_done |=> (!sto && !scl_oe && !sda_oe));
endmodule

bind i2c_hold_master i2c_hold_checker chk_i (
  .clk(clk), .rst_n(rst_n), .si(si), .sto(sto), .sto_done(sto_done),
  .ev_valid(ev_valid), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_hold_master_tb.sv
`timescale 1ns/1ps
module i2c_hold_master_tb_top;
  localparam logic [1:0] A_SET = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_CLR = 2'd3;
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] q = 8'd3;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic slv_lo;
  wire  scl_ln = ~scl_oe;
  wire  sda_ln = ~(sda_oe | slv_lo);

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_hold_master #(.DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_quarter(q), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_ln),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  // ---------------- memory slave model ----------------
  logic p_scl, p_sda, is_addr, rdm, sel, ptr_set, mack, nack_data = 1'b0, was_addr;
  logic [7:0] inb, txb;
  logic [3:0] ptr;
  int bcnt;
  logic [7:0] mem [16];
  logic [7:0] exp_mem [16];

  always @(negedge clk) begin
    logic c_scl, c_sda;
    c_scl = scl_ln; c_sda = sda_ln;
    if (!rst_n) begin
      slv_lo = 0; p_scl = 1; p_sda = 1; bcnt = 0; sel = 0; is_addr = 0;
      rdm = 0; ptr_set = 0; mack = 0; ptr = 0;
    end else begin
      if (c_scl && p_scl && p_sda && !c_sda) begin
        bcnt = 0; is_addr = 1; sel = 0; rdm = 0; ptr_set = 0; slv_lo = 0;
      end else if (c_scl && p_scl && !p_sda && c_sda) begin
        sel = 0; bcnt = 0; is_addr = 0; slv_lo = 0;
      end else if (c_scl && !p_scl) begin
        if (bcnt < 8) begin inb = {inb[6:0], c_sda}; bcnt++; end
        else if (bcnt == 8) begin mack = !c_sda; bcnt = 9; end
      end else if (!c_scl && p_scl) begin
        if (bcnt == 8) begin
          if (is_addr) begin sel = (inb[7:1] == SLV); rdm = inb[0]; slv_lo = sel; end
          else if (sel && !rdm) begin
            if (!ptr_set) begin ptr = inb[3:0]; ptr_set = 1; end
            else begin mem[ptr] = inb; ptr++; end
            slv_lo = !nack_data;
          end else slv_lo = 0;
        end else if (bcnt == 9) begin
          was_addr = is_addr; is_addr = 0; bcnt = 0;
          if (sel && rdm && (was_addr || mack)) begin
            txb = mem[ptr]; ptr++; slv_lo = !txb[7];
          end else begin slv_lo = 0; if (sel && rdm) sel = 0; end
        end else if (sel && rdm && !is_addr && bcnt >= 1) slv_lo = !txb[7-bcnt];
      end
      p_scl = c_scl; p_sda = c_sda;
    end
  end

  // SCL high-run measurement (R10)
  int run = 0, last_high = 0;
  always @(negedge clk) begin
    if (scl_ln) run++;
    else begin if (run > 0) last_high = run; run = 0; end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_si(input string req);
    logic [7:0] c;
    for (int i = 0; i < 20000; i++) begin
      rd(A_SET, c);
      if (c[3]) return;
    end
    check(0, req, 0, 1);
  endtask

  function automatic logic [7:0] tx_code(bit is_addr, bit rw, bit ack);
    if (is_addr) return rw ? (ack ? 8'h40 : 8'h48) : (ack ? 8'h18 : 8'h20);
    return ack ? 8'h28 : 8'h30;
  endfunction

  function automatic logic [7:0] rx_code(bit ack);
    return ack ? 8'h50 : 8'h58;
  endfunction

  task automatic do_start(output logic [7:0] st);
    wr(A_SET, 8'h20); wait_si("R3"); rd(A_STAT, st); wr(A_CLR, 8'h20);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic [7:0] st);
    wr(A_DATA, d); wr(A_CLR, 8'h08); wait_si("R6"); rd(A_STAT, st);
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] d, output logic [7:0] st);
    wr(ack ? A_SET : A_CLR, 8'h04); wr(A_CLR, 8'h08); wait_si("R7");
    rd(A_STAT, st); rd(A_DATA, d);
  endtask

  task automatic do_stop();
    logic [7:0] c, s;
    wr(A_SET, 8'h10); wr(A_CLR, 8'h08);
    for (int i = 0; i < 20000; i++) begin rd(A_SET, c); if (!c[4]) break; end
    rd(A_STAT, s);
    check(c == 8'h00 && s == 8'hF8, "R8 stop ctrl/status", {c, s}, 16'h00F8);
    check(!scl_oe && !sda_oe && !irq, "R8 lines released", {scl_oe, sda_oe, irq}, 0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] c, s, d, s2;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 16; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1
    rd(A_SET, c); rd(A_STAT, s);
    check(c == 8'h00, "R1 ctrl reset", c, 0);
    check(s == 8'hF8, "R1 status reset", s, 8'hF8);
    check(!scl_oe && !sda_oe && !irq, "R1 lines", {scl_oe, sda_oe, irq}, 0);
    // R2
    wr(A_SET, 8'h04); rd(A_SET, c); check(c == 8'h04, "R2 set AA", c, 8'h04);
    wr(A_SET, 8'h00); rd(A_SET, c); check(c == 8'h04, "R2 zero set no effect", c, 8'h04);
    wr(A_SET, 8'h08); rd(A_SET, c);
    check(c == 8'h04 && !irq && !scl_oe, "R2 SI not settable", c, 8'h04);
    wr(A_CLR, 8'h00); rd(A_SET, c); check(c == 8'h04, "R2 zero clear no effect", c, 8'h04);
    wr(A_CLR, 8'h04); rd(A_SET, c); check(c == 8'h00, "R2 clear AA", c, 0);
    // R3 + R4
    wr(A_SET, 8'h20); wait_si("R3"); rd(A_STAT, s); rd(A_SET, c);
    check(s == 8'h08, "R3 start status", s, 8'h08);
    check(c == 8'h28, "R3 ctrl after start", c, 8'h28);
    wr(A_CLR, 8'h20);
    d = {7'b0, sda_oe};
    repeat (300) @(negedge clk);
    rd(A_STAT, s);
    check(scl_oe && sda_oe == d[0] && s == 8'h08, "R4 hold after start", {scl_oe, sda_oe, s}, {2'b11, 8'h08});
    send_byte({SLV, 1'b0}, s); check(s == tx_code(1, 0, 1), "R6 addr W ack", s, tx_code(1, 0, 1));
    check(last_high == 2 * (q + 1), "R10 SCL high q=3", last_high, 2 * (q + 1));
    send_byte(8'h02, s); check(s == tx_code(0, 0, 1), "R6 ptr ack", s, tx_code(0, 0, 1));
    send_byte(8'h5A, s); exp_mem[2] = 8'h5A; check(s == 8'h28, "R6 data ack", s, 8'h28);
    send_byte(8'hC3, s); exp_mem[3] = 8'hC3; check(s == 8'h28, "R6 data ack 2", s, 8'h28);
    do_stop();
    // queued repeated start (R4, R5)
    do_start(s);
    send_byte({SLV, 1'b0}, s); send_byte(8'h02, s);
    wr(A_SET, 8'h20);
    d = {7'b0, sda_oe};
    repeat (400) @(negedge clk);
    rd(A_STAT, s);
    check(scl_oe && sda_oe == d[0] && s == 8'h28, "R4 STA queued behind SI", s, 8'h28);
    wr(A_CLR, 8'h08); wait_si("R5"); rd(A_STAT, s);
    check(s == 8'h10, "R5 repeated start", s, 8'h10);
    rd(A_SET, c); check(c[5], "R9 STA not self-cleared", c, 8'h28);
    wr(A_CLR, 8'h20);
    send_byte({SLV, 1'b1}, s); check(s == tx_code(1, 1, 1), "R6 addr R ack", s, 8'h40);
    recv_byte(1, d, s);
    check(s == rx_code(1), "R7 rx ack status", s, 8'h50);
    check(d == exp_mem[2], "R7 rx data 0", d, exp_mem[2]);
    recv_byte(0, d, s);
    check(s == rx_code(0), "R7 rx nack status", s, 8'h58);
    check(d == exp_mem[3], "R7 rx data 1", d, exp_mem[3]);
    do_stop();
    // R9: STA beats STO, STO kept for next clear
    do_start(s); send_byte({SLV, 1'b0}, s);
    wr(A_SET, 8'h30); wr(A_CLR, 8'h08); wait_si("R9"); rd(A_STAT, s); rd(A_SET, c);
    check(s == 8'h10 && c == 8'h38, "R9 STA over STO", {c, s}, 16'h3810);
    wr(A_CLR, 8'h20); wr(A_CLR, 8'h08);
    for (int i = 0; i < 20000; i++) begin rd(A_SET, c); if (!c[4]) break; end
    rd(A_STAT, s);
    check(c == 8'h00 && s == 8'hF8 && !scl_oe && !sda_oe, "R9 pending STO runs", {c, s}, 16'h00F8);
    // refusals (R6)
    do_start(s); send_byte(8'hB0, s); check(s == tx_code(1, 0, 0), "R6 addr W nack", s, 8'h20); do_stop();
    do_start(s); send_byte(8'hB1, s); check(s == tx_code(1, 1, 0), "R6 addr R nack", s, 8'h48); do_stop();
    nack_data = 1;
    do_start(s); send_byte({SLV, 1'b0}, s); send_byte(8'h07, s);
    check(s == tx_code(0, 0, 0), "R6 data nack", s, 8'h30); do_stop();
    nack_data = 0;
    // randomized write-then-read (R6, R7, R10)
    for (int t = 0; t < 6; t++) begin
      logic [3:0] p;
      int n;
      q = 8'($urandom_range(1, 3));
      p = 4'($urandom_range(0, 15));
      n = $urandom_range(1, 3);
      do_start(s); check(s == 8'h08, "R3 random start", s, 8'h08);
      send_byte({SLV, 1'b0}, s); send_byte({4'h0, p}, s);
      for (int k = 0; k < n; k++) begin
        logic [7:0] v;
        v = 8'($urandom);
        send_byte(v, s); exp_mem[4'(p + k)] = v;
        check(s == 8'h28, "R6 random data ack", s, 8'h28);
      end
      check(last_high == 2 * (q + 1), "R10 SCL high random q", last_high, 2 * (q + 1));
      do_stop();
      do_start(s); send_byte({SLV, 1'b0}, s); send_byte({4'h0, p}, s);
      wr(A_SET, 8'h20); wr(A_CLR, 8'h08); wait_si("R5"); rd(A_STAT, s2); wr(A_CLR, 8'h20);
      check(s2 == 8'h10, "R5 random rstart", s2, 8'h10);
      send_byte({SLV, 1'b1}, s);
      for (int k = 0; k < n; k++) begin
        bit a;
        a = (k != n - 1);
        recv_byte(a, d, s);
        check(s == rx_code(a), "R7 random rx status", s, rx_code(a));
        check(d == exp_mem[4'(p + k)], "R7 random rx data", d, exp_mem[4'(p + k)]);
      end
      do_stop();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule